// File: doc/BRIEF.md
# Frequency Integral Path for a Digital Clock-Recovery Loop

This block is the frequency-tracking branch of a second-order digital clock-recovery loop. Each accepted input is a signed early/late vote count from the upstream prefilter. The block halves that count and adds it to a saturating frequency estimate. The estimate is a signed fixed-point word with `INT_W` integer bits and `FRAC_W` fractional bits. A first-order sigma-delta stage then turns the estimate into a stream of single phase steps, one per cycle. The long-run rate of those steps is proportional to the estimate. Downstream logic adds these steps to the proportional-path steps before the phase rotator.

The estimate is updated in two pipelined pieces. A fractional integrator takes the scaled input and produces a carry or borrow. An integer integrator absorbs that carry one cycle later. The step generator reads the assembled word one cycle after that. The block tolerates this extra latency because the frequency branch matters only at low jitter frequencies. Saturation is decided in the fractional stage, which looks ahead at the integer value that is about to be written. As a result, the assembled word clamps at its exact signed limits and never wraps.

Top module: `freq_integ_path`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the frequency estimate, the pending carry and the step residue. After the reset edge `step_o` is 0 and stays 0 until new input is accepted.
- R2: A cycle with `cnt_vld` low leaves the frequency estimate unchanged, whatever value `cnt_in` carries.
- R3: Each accepted count c adds c·2^(FRAC_W−1) LSBs to the estimate, which is a counter gain of 0.5. With FRAC_W=6, one accepted +1 gives an estimate of 32 LSBs.
- R4: Fractional overflow carries into the integer part, and fractional underflow borrows from it. The result is a correct signed two's-complement word across the integer boundary in both directions.
- R5: The estimate saturates at +(2^(INT_W+FRAC_W−1)−1) and at −2^(INT_W+FRAC_W−1) and never wraps. With the defaults these limits are +511 and −512.
- R6: `step_o` is a 2-bit two's-complement value taken only from {01 = +1, 00 = 0, 11 = −1}. The code 10 never appears.
- R7: The residue is kept from cycle to cycle. Over any window, the number of +1 steps minus the number of −1 steps equals F·N/2^(INT_W+FRAC_W−1) to within one step, where F is a constant estimate and N is the window length.
- R8: A count accepted at rising edge k first affects `step_o` at edge k+2. There is one cycle in the fractional stage, one in the integer stage, and the step register is updated at edge k+2.
- R9: A +1 step occurs only when the estimate is non-negative, and a −1 step occurs only when it is negative. At the negative limit, −1 is emitted every cycle.
- R10: Input codes beyond ±2 (+3, −3, −4) are clipped to ±2 before scaling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Loop clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_vld | input | 1 | Strobe qualifying `cnt_in` this cycle |
| cnt_in | input | 3 | Signed early/late count, nominal range −2..+2 |
| step_o | output | 2 | Signed phase step per cycle: −1, 0 or +1 |

## Verification
A behavioural model in the bench saturates a plain integer accumulator. It feeds the result through a two-deep delay and a residue counter, and the model is compared against `step_o` on every cycle. The bench drives several patterns. Single ±1 pulses expose the 0.5 gain and the borrow across zero. Runs of +2 and −2 drive the word into both limits, which would reveal a wrap or a one-LSB clamp error. Out-of-range codes must match the ±2 result, and strobes held low with a nonzero count must leave the estimate alone. Step counts over long windows at a fixed estimate check the rate. A lone −1 pulse after reset pins the two-cycle latency exactly.

// File: rtl/fip_pkg.sv
package fip_pkg;

  localparam int CNT_W  = 3;
  localparam int STEP_W = 2;

  typedef logic signed [CNT_W-1:0]  cnt_t;
  typedef logic signed [STEP_W-1:0] step_t;

  // Clip an input vote count to the nominal -2..+2 range.
  function automatic cnt_t clip_cnt(input cnt_t c);
    if (c > 3'sd2)  return 3'sd2;
    if (c < -3'sd2) return -3'sd2;
    return c;
  endfunction

endpackage

// File: rtl/fip_frac_stage.sv
module fip_frac_stage
  import fip_pkg::*;
#(
  parameter int FRAC_W = 6,
  parameter int INT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cnt_vld,
  input  cnt_t                    cnt,
  input  logic signed [INT_W-1:0] int_now,
  input  logic signed [1:0]       carry_now,
  output logic [FRAC_W-1:0]       frac_q,
  output logic signed [1:0]       carry_q,
  output logic                    pin_hi,
  output logic                    pin_lo
);

  localparam int SUM_W = FRAC_W + 2;
  localparam int EXT_W = SUM_W - CNT_W;
  localparam logic signed [SUM_W-1:0] FULL = SUM_W'(1 << FRAC_W);
  localparam logic signed [INT_W:0] E_MAX = (INT_W+1)'((1 << (INT_W-1)) - 1);
  localparam logic signed [INT_W:0] E_MIN = -(INT_W+1)'(1 << (INT_W-1));

  cnt_t                    c_clip;
  logic signed [SUM_W-1:0] c_ext;
  logic signed [SUM_W-1:0] inc;
  logic signed [SUM_W-1:0] sum;
  logic signed [INT_W:0]   int_ahead;
  logic [FRAC_W-1:0]       frac_d;
  logic signed [1:0]       carry_d;

  // Integer value that the integer stage is about to hold.
  function automatic logic signed [INT_W:0] look_ahead(
    input logic signed [INT_W-1:0] iv,
    input logic signed [1:0]       cv
  );
    return {iv[INT_W-1], iv} + {{(INT_W-1){cv[1]}}, cv};
  endfunction

  always_comb begin
    c_clip    = clip_cnt(cnt);
    c_ext     = {{EXT_W{c_clip[CNT_W-1]}}, c_clip};
    inc       = c_ext <<< (FRAC_W-1);
    sum       = $signed({2'b00, frac_q}) + inc;
    int_ahead = look_ahead(int_now, carry_now);
    pin_hi    = (int_ahead == E_MAX) && (sum >= FULL);
    pin_lo    = (int_ahead == E_MIN) && sum[SUM_W-1];
    frac_d    = sum[FRAC_W-1:0];
    carry_d   = sum[SUM_W-1:FRAC_W];
    if (pin_hi) begin
      frac_d  = '1;
      carry_d = 2'sd0;
    end else if (pin_lo) begin
      frac_d  = '0;
      carry_d = 2'sd0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frac_q  <= '0;
      carry_q <= 2'sd0;
    end else if (cnt_vld) begin
      frac_q  <= frac_d;
      carry_q <= carry_d;
    end else begin
      carry_q <= 2'sd0;
    end
  end

endmodule

// File: rtl/fip_int_stage.sv
module fip_int_stage #(
  parameter int FRAC_W = 6,
  parameter int INT_W  = 4,
  localparam int W     = INT_W + FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [1:0]       carry_in,
  input  logic [FRAC_W-1:0]       frac_in,
  output logic signed [W-1:0]     freq_q,
  output logic signed [INT_W-1:0] int_q
);

  logic signed [INT_W-1:0] int_sum;

  function automatic logic signed [INT_W-1:0] absorb(
    input logic signed [INT_W-1:0] iv,
    input logic signed [1:0]       cv
  );
    return iv + {{(INT_W-2){cv[1]}}, cv};
  endfunction

  assign int_q   = freq_q[W-1:FRAC_W];
  assign int_sum = absorb(int_q, carry_in);

  always_ff @(posedge clk) begin
    if (rst) freq_q <= '0;
    else     freq_q <= {int_sum, frac_in};
  end

endmodule

// File: rtl/fip_step_gen.sv
module fip_step_gen
  import fip_pkg::*;
#(
  parameter int W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] freq,
  output step_t               step_q
);

  localparam int T_W = W + 2;
  localparam logic signed [T_W-1:0] K = T_W'(1 << (W-1));

  logic [W-2:0]          res_q;
  logic signed [T_W-1:0] tot;
  step_t                 step_d;

  function automatic step_t decide(input logic signed [T_W-1:0] t);
    if (t >= K)       return 2'sd1;
    if (t < T_W'(0))  return -2'sd1;
    return 2'sd0;
  endfunction

  always_comb begin
    tot    = $signed({3'b000, res_q}) + {{2{freq[W-1]}}, freq};
    step_d = decide(tot);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      step_q <= 2'sd0;
    end else begin
      res_q  <= tot[W-2:0];
      step_q <= step_d;
    end
  end

endmodule

// File: rtl/freq_integ_path.sv
module freq_integ_path
  import fip_pkg::*;
#(
  parameter int FRAC_W = 6,
  parameter int INT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_vld,
  input  logic signed [2:0] cnt_in,
  output logic signed [1:0] step_o
);

  localparam int W = INT_W + FRAC_W;

  logic [FRAC_W-1:0]       frac_w;
  logic signed [1:0]       carry_w;
  logic signed [W-1:0]     freq_w;
  logic signed [INT_W-1:0] int_w;
  logic                    pin_hi_w;
  logic                    pin_lo_w;
  step_t                   step_w;

  fip_frac_stage #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_frac (
    .clk      (clk),
    .rst      (rst),
    .cnt_vld  (cnt_vld),
    .cnt      (cnt_in),
    .int_now  (int_w),
    .carry_now(carry_w),
    .frac_q   (frac_w),
    .carry_q  (carry_w),
    .pin_hi   (pin_hi_w),
    .pin_lo   (pin_lo_w)
  );

  fip_int_stage #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_int (
    .clk     (clk),
    .rst     (rst),
    .carry_in(carry_w),
    .frac_in (frac_w),
    .freq_q  (freq_w),
    .int_q   (int_w)
  );

  fip_step_gen #(.W(W)) u_step (
    .clk   (clk),
    .rst   (rst),
    .freq  (freq_w),
    .step_q(step_w)
  );

  assign step_o = step_w;

endmodule

// File: rtl/freq_integ_path_chk.sv
module freq_integ_path_chk #(
  parameter int W     = 10,
  parameter int INT_W = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_vld,
  input logic signed [1:0]       step,
  input logic signed [W-1:0]     freq,
  input logic signed [INT_W-1:0] int_q,
  input logic signed [1:0]       carry,
  input logic                    pin_hi,
  input logic                    pin_lo
);

  localparam logic signed [INT_W-1:0] I_MAX = INT_W'((1 << (INT_W-1)) - 1);
  localparam logic signed [INT_W-1:0] I_MIN = -INT_W'(1 << (INT_W-1));
  localparam logic signed [W-1:0]     F_MAX = W'((1 << (W-1)) - 1);
  localparam logic signed [W-1:0]     F_MIN = -W'(1 << (W-1));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (step == 2'sd0 && freq == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_vld ##1 !in_vld) |=> $stable(freq));

  // R5
  int_top_chk: assert property (@(posedge clk) disable iff (rst)
    !(int_q == I_MAX && carry == 2'sd1));

  // R5
  int_bot_chk: assert property (@(posedge clk) disable iff (rst)
    !(int_q == I_MIN && carry == -2'sd1));

  // R5
  max_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (freq == F_MAX) |=> !freq[W-1]);

  // R5
  min_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (freq == F_MIN) |=> freq[W-1]);

  // R5
  pin_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pin_hi && pin_lo));

  // R6
  step_code_chk: assert property (@(posedge clk) disable iff (rst)
    step != 2'b10);

  // R9
  neg_step_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (step == -2'sd1) |-> $past(freq[W-1]));

  // R9
  pos_step_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (step == 2'sd1) |-> !$past(freq[W-1]));

endmodule

bind freq_integ_path freq_integ_path_chk #(.W(W), .INT_W(INT_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .in_vld(cnt_vld),
  .step  (step_o),
  .freq  (freq_w),
  .int_q (int_w),
  .carry (carry_w),
  .pin_hi(pin_hi_w),
  .pin_lo(pin_lo_w)
);

// File: tb/freq_integ_path_tb.sv
module freq_integ_path_tb;

  localparam int FRAC_W = 6;
  localparam int INT_W  = 4;
  localparam int W      = INT_W + FRAC_W;
  localparam int K      = 1 << (W-1);
  localparam int HALF   = 1 << (FRAC_W-1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cnt_vld = 1'b0;
  logic signed [2:0] cnt_in = 3'sd0;
  logic signed [1:0] step_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model state
  int m_f1 = 0;
  int m_f2 = 0;
  int m_res = 0;
  int m_step = 0;
  int m_t;
  int m_c;

  always #10 clk = ~clk;

  freq_integ_path #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_dut (
    .clk    (clk),
    .rst    (rst),
    .cnt_vld(cnt_vld),
    .cnt_in (cnt_in),
    .step_o (step_o)
  );

  function automatic int clip(input int c);
    if (c > 2)  return 2;
    if (c < -2) return -2;
    return c;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_f1 = 0; m_f2 = 0; m_res = 0; m_step = 0;
    end else begin
      m_t = m_res + m_f2;
      if (m_t >= K)     begin m_step = 1;  m_t = m_t - K; end
      else if (m_t < 0) begin m_step = -1; m_t = m_t + K; end
      else                    m_step = 0;
      m_res = m_t;
      m_f2  = m_f1;
      if (cnt_vld) begin
        m_c  = clip(int'(cnt_in));
        m_f1 = m_f1 + m_c * HALF;
        if (m_f1 > K - 1) m_f1 = K - 1;
        if (m_f1 < -K)    m_f1 = -K;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model; R6 code check alongside
  always @(negedge clk) begin
    if (!done) begin
      chk(int'(step_o) == m_step, cur_req, int'(step_o), m_step);
      chk(step_o != 2'b10, "R6", int'(step_o), 0);
    end
  end

  task automatic drive(input logic v, input logic signed [2:0] c, input int n);
    repeat (n) begin
      @(negedge clk);
      cnt_vld = v;
      cnt_in  = c;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cnt_vld = 1'b0; cnt_in = 3'sd0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  int pos_n;
  int neg_n;
  task automatic window(input int n);
    pos_n = 0; neg_n = 0;
    repeat (n) begin
      @(negedge clk);
      #1;
      if (step_o == 2'sd1)  pos_n++;
      if (step_o == -2'sd1) neg_n++;
    end
  endtask

  function automatic bit near(input int a, input int b);
    return (a >= b - 1) && (a <= b + 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL R8: run did not complete, actual timeout expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    window(20);
    chk(pos_n + neg_n == 0, "R1", pos_n + neg_n, 0);

    // R2: strobe low with a nonzero count has no effect
    cur_req = "R2";
    drive(1'b0, 3'sd2, 200);
    window(50);
    chk(pos_n + neg_n == 0, "R2", pos_n + neg_n, 0);

    // R8: lone -1 at edge k gives -1 at edge k+2 and not earlier
    cur_req = "R8";
    do_reset();
    @(negedge clk); cnt_vld = 1'b1; cnt_in = -3'sd1;
    @(negedge clk); cnt_vld = 1'b0; cnt_in = 3'sd0;
    chk(step_o == 2'sd0, "R8", int'(step_o), 0);
    @(negedge clk);
    chk(step_o == 2'sd0, "R8", int'(step_o), 0);
    @(negedge clk);
    chk(step_o == -2'sd1, "R8", int'(step_o), -1);

    // R3: one +1 gives 32 LSBs -> 32 steps per 512 cycles
    cur_req = "R3";
    do_reset();
    drive(1'b1, 3'sd1, 1);
    drive(1'b0, 3'sd0, 4);
    window(512);
    chk(near(pos_n, 32) && neg_n == 0, "R3", pos_n, 32);

    // R4: carry up to 64, then borrow down to -32
    cur_req = "R4";
    drive(1'b1, 3'sd1, 1);
    drive(1'b0, 3'sd0, 4);
    window(512);
    chk(near(pos_n, 64), "R4", pos_n, 64);
    drive(1'b1, -3'sd1, 3);
    drive(1'b0, 3'sd0, 4);
    window(512);
    chk(near(neg_n, 32) && pos_n == 0, "R4", neg_n, 32);

    // R7: estimate 96 -> 192 steps over 1024 cycles
    cur_req = "R7";
    do_reset();
    drive(1'b1, 3'sd1, 3);
    drive(1'b0, 3'sd0, 4);
    window(1024);
    chk(near(pos_n, 192), "R7", pos_n, 192);

    // R10: +3 acts as +2, -4 acts as -2
    cur_req = "R10";
    do_reset();
    drive(1'b1, 3'sd3, 4);
    drive(1'b0, 3'sd0, 4);
    window(512);
    chk(near(pos_n, 256), "R10", pos_n, 256);
    drive(1'b1, 3'b100, 12);
    drive(1'b1, -3'sd3, 2);
    drive(1'b0, 3'sd0, 4);
    window(100);
    chk(neg_n == 100, "R10", neg_n, 100);

    // R5: drive into upper limit, then lower limit
    cur_req = "R5";
    do_reset();
    drive(1'b1, 3'sd2, 40);
    drive(1'b0, 3'sd0, 4);
    window(512);
    chk(near(pos_n, 511) && neg_n == 0, "R5", pos_n, 511);
    drive(1'b1, -3'sd2, 40);
    drive(1'b0, 3'sd0, 4);
    window(200);
    chk(neg_n == 200, "R5", neg_n, 200);

    // R9: at the negative limit no +1 ever appears
    cur_req = "R9";
    drive(1'b1, -3'sd2, 30);
    window(100);
    chk(pos_n == 0 && neg_n == 100, "R9", pos_n, 0);

    // R1: reset in mid-run clears everything
    cur_req = "R1";
    do_reset();
    drive(1'b0, 3'sd0, 1);
    window(30);
    chk(pos_n + neg_n == 0, "R1", pos_n + neg_n, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule